// File: doc/BRIEF.md
# Bus-START Refreshed Watchdog Timer

This block is a watchdog timer that software never has to write to. Any START condition seen on the two-wire serial bus lines counts as a refresh. The block samples the already-synchronized clock and data lines on every system clock. When data falls while the clock line stays high, the timeout counter reloads to the full selected period. A tick enable sets the pace of the countdown. If the counter runs out before another START arrives, the block asserts a reset request for a fixed number of clock cycles. It then reloads and begins counting again.

A two-bit select input picks one of three timeout lengths or switches the watchdog off. In the off setting the counter is parked and never counts, so it uses no switching power. The block ignores any START that arrives while its own reset pulse is running or while the external supervisor flags a reset. It also gives a standby indication: this is low after an accepted START and returns high when a STOP is seen.

Top module: `bus_watchdog`

## Requirements
- R1: A START is one system clock on which SDA is sampled high and then low while SCL is sampled high on both clocks. An accepted START reloads the counter to the selected period, in ticks.
- R2: With no START, `wd_rst_o` rises on the clock edge that takes the P-th tick since the last reload, where P is the selected period. It stays low for the first P-1 ticks.
- R3: Select code 2'b00 gives period P_LONG, 2'b01 gives P_MID and 2'b10 gives P_SHORT.
- R4: Select code 2'b11 turns the watchdog off. The counter is idle, ticks are ignored and `wd_rst_o` stays low.
- R5: The reset request stays high for exactly PULSE_LEN clock cycles. The counter then reloads to the selected period and counts again.
- R6: A START has no effect on the counter or on standby in two cases: while `wd_rst_o` is high, or while `sup_reset_i` is high.
- R7: Any change of the select input reloads the counter to the newly chosen period on the next clock. This also ends a reset pulse that is running.
- R8: After reset, `wd_rst_o` is 0 and `standby_o` is 1. An accepted START drives `standby_o` to 0. A STOP (SDA sampled low then high while SCL is high on both clocks) drives it back to 1.
- R9: SDA changes while SCL is low produce neither a START nor a STOP.
- R10: If a START and a tick fall on the same clock, the START wins and the counter holds the full period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronized serial clock line |
| sda_i | input | 1 | Synchronized serial data line |
| wd_sel_i | input | 2 | Timeout select (00 long, 01 mid, 10 short, 11 off) |
| tick_i | input | 1 | Countdown tick enable, one clock wide |
| sup_reset_i | input | 1 | External supervisor reset is active |
| wd_rst_o | output | 1 | Watchdog reset request |
| standby_o | output | 1 | High when no bus transfer has been opened by a START |

## Verification
The bench builds the block with periods of 12, 7 and 4 ticks and a 6-cycle reset pulse. At these sizes every timeout can be counted out exactly to its edge tick, and a START can be placed well inside a running pulse. This lets the bench check each period against its neighbour tick, and check the pulse length both whole and after an ignored START. It also covers a select change in the middle of a countdown and a START that lands on the same clock as a tick.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    typedef enum logic [1:0] {
        SEL_LONG  = 2'b00,
        SEL_MID   = 2'b01,
        SEL_SHORT = 2'b10,
        SEL_OFF   = 2'b11
    } wd_sel_e;

    typedef enum logic [1:0] {
        ST_OFF   = 2'b00,
        ST_RUN   = 2'b01,
        ST_PULSE = 2'b10
    } wd_state_e;

    typedef struct packed {
        logic start;
        logic stop;
    } bus_cond_t;

endpackage

// File: rtl/wdg_bus_cond.sv
module wdg_bus_cond
    import wdg_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      scl_i,
    input  logic      sda_i,
    output bus_cond_t cond_o
);

    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    // Conditions only while the clock line is high on both samples
    always_comb begin
        cond_o.start = scl_q && scl_i && sda_q && !sda_i;
        cond_o.stop  = scl_q && scl_i && !sda_q && sda_i;
    end

    // R9
    no_cond_low_chk: assert property (@(posedge clk) disable iff (rst)
        !scl_i |-> (cond_o == '0));

endmodule

// File: rtl/wdg_standby.sv
module wdg_standby
    import wdg_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  bus_cond_t cond_i,
    input  logic      block_i,
    output logic      standby_o
);

    logic busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
        end else if (cond_i.stop) begin
            busy_q <= 1'b0;
        end else if (cond_i.start && !block_i) begin
            busy_q <= 1'b1;
        end
    end

    assign standby_o = !busy_q;

    // R8
    sb_start_chk: assert property (@(posedge clk) disable iff (rst)
        (cond_i.start && !block_i) |=> !standby_o);

    // R8
    sb_stop_chk: assert property (@(posedge clk) disable iff (rst)
        cond_i.stop |=> standby_o);

    // R6
    sb_block_chk: assert property (@(posedge clk) disable iff (rst)
        (block_i && standby_o) |=> standby_o);

endmodule

// File: rtl/wdg_timer.sv
module wdg_timer
    import wdg_pkg::*;
#(
    parameter int unsigned P_LONG    = 1400,
    parameter int unsigned P_MID     = 600,
    parameter int unsigned P_SHORT   = 200,
    parameter int unsigned PULSE_LEN = 250
) (
    input  logic    clk,
    input  logic    rst,
    input  wd_sel_e sel_i,
    input  logic    tick_i,
    input  logic    start_i,
    input  logic    hold_i,
    output logic    rst_req_o
);

    localparam int unsigned CW = $clog2(P_LONG + 1);
    localparam int unsigned PW = $clog2(PULSE_LEN + 1);

    wd_state_e     state;
    wd_sel_e       sel_q;
    logic [CW-1:0] cnt;
    logic [PW-1:0] pcnt;
    logic          sel_chg;

    function automatic logic [CW-1:0] load_val(wd_sel_e s);
        case (s)
            SEL_LONG:  return CW'(P_LONG);
            SEL_MID:   return CW'(P_MID);
            SEL_SHORT: return CW'(P_SHORT);
            default:   return '0;
        endcase
    endfunction

    assign sel_chg = (sel_i != sel_q);

    always_ff @(posedge clk) begin
        if (rst || sel_chg) begin
            sel_q <= sel_i;
            pcnt  <= '0;
            cnt   <= load_val(sel_i);
            state <= (sel_i == SEL_OFF) ? ST_OFF : ST_RUN;
        end else begin
            case (state)
                ST_RUN: begin
                    if (start_i && !hold_i) begin
                        cnt <= load_val(sel_q);
                    end else if (tick_i) begin
                        if (cnt <= CW'(1)) begin
                            state <= ST_PULSE;
                            pcnt  <= PW'(PULSE_LEN);
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt - CW'(1);
                        end
                    end
                end
                ST_PULSE: begin
                    if (pcnt <= PW'(1)) begin
                        state <= ST_RUN;
                        pcnt  <= '0;
                        cnt   <= load_val(sel_q);
                    end else begin
                        pcnt <= pcnt - PW'(1);
                    end
                end
                default: begin
                    cnt <= '0;
                end
            endcase
        end
    end

    assign rst_req_o = (state == ST_PULSE);

    // R1
    reload_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && !sel_chg && start_i && !hold_i) |=>
            (cnt == load_val(sel_q) && !rst_req_o));

    // R2
    expire_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && !sel_chg && tick_i && !start_i && cnt == CW'(1)) |=>
            rst_req_o);

    // R4
    off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (sel_q == SEL_OFF && !sel_chg) |=> (!rst_req_o && cnt == '0));

    // R6
    pulse_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PULSE && !sel_chg && pcnt > PW'(1)) |=>
            (rst_req_o && pcnt == $past(pcnt) - PW'(1)));

    // R7
    selchg_chk: assert property (@(posedge clk) disable iff (rst)
        (sel_chg && sel_i != SEL_OFF) |=>
            (state == ST_RUN && cnt == load_val(sel_q)));

endmodule

// File: rtl/bus_watchdog.sv
module bus_watchdog
    import wdg_pkg::*;
#(
    parameter int unsigned P_LONG    = 1400,
    parameter int unsigned P_MID     = 600,
    parameter int unsigned P_SHORT   = 200,
    parameter int unsigned PULSE_LEN = 250
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [1:0] wd_sel_i,
    input  logic       tick_i,
    input  logic       sup_reset_i,
    output logic       wd_rst_o,
    output logic       standby_o
);

    bus_cond_t cond;
    wd_sel_e   sel;
    logic      rst_req;

    assign sel = wd_sel_e'(wd_sel_i);

    wdg_bus_cond u_cond (
        .clk    (clk),
        .rst    (rst),
        .scl_i  (scl_i),
        .sda_i  (sda_i),
        .cond_o (cond)
    );

    wdg_timer #(
        .P_LONG    (P_LONG),
        .P_MID     (P_MID),
        .P_SHORT   (P_SHORT),
        .PULSE_LEN (PULSE_LEN)
    ) u_timer (
        .clk       (clk),
        .rst       (rst),
        .sel_i     (sel),
        .tick_i    (tick_i),
        .start_i   (cond.start),
        .hold_i    (sup_reset_i),
        .rst_req_o (rst_req)
    );

    wdg_standby u_standby (
        .clk       (clk),
        .rst       (rst),
        .cond_i    (cond),
        .block_i   (rst_req || sup_reset_i),
        .standby_o (standby_o)
    );

    assign wd_rst_o = rst_req;

    // R5
    pulse_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(wd_rst_o) |-> $past(tick_i));

endmodule

// File: tb/bus_watchdog_test.sv
module bus_watchdog_test;

    localparam int PL = 12;
    localparam int PM = 7;
    localparam int PS = 4;
    localparam int PW = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl = 1'b1;
    logic       sda = 1'b1;
    logic [1:0] sel = 2'b00;
    logic       tick = 1'b0;
    logic       sup = 1'b0;
    logic       wd_rst;
    logic       standby;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    bus_watchdog #(.P_LONG(PL), .P_MID(PM), .P_SHORT(PS), .PULSE_LEN(PW)) uut (
        .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda), .wd_sel_i(sel),
        .tick_i(tick), .sup_reset_i(sup), .wd_rst_o(wd_rst), .standby_o(standby)
    );

    typedef struct {
        string req;
        int    e_rst;
        int    e_sb;
    } exp_t;

    exp_t q[$];
    event chk_ev;

    // Driver side: push expectation for the present port values
    task automatic expect_ports(string r, int e_rst, int e_sb);
        exp_t e;
        e.req = r; e.e_rst = e_rst; e.e_sb = e_sb;
        q.push_back(e);
        -> chk_ev;
        #1;
    endtask

    // Monitor: pop and compare against the ports
    initial begin : monitor
        exp_t e;
        forever begin
            @(chk_ev);
            while (q.size() > 0) begin
                e = q.pop_front();
                checks++;
                if (int'(wd_rst) != e.e_rst ||
                    (e.e_sb >= 0 && int'(standby) != e.e_sb)) begin
                    errors++;
                    $display("FAIL %s: wd_rst=%0d standby=%0d expected wd_rst=%0d standby=%0d",
                             e.req, wd_rst, standby, e.e_rst, e.e_sb);
                end
            end
        end
    end

    task automatic check_val(string r, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", r, act, exp);
        end
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
        end
    endtask

    task automatic send_start(bit with_tick);
        @(negedge clk) begin scl = 1'b1; sda = 1'b1; end
        @(negedge clk) begin sda = 1'b0; tick = with_tick; end
        @(negedge clk) begin tick = 1'b0; scl = 1'b0; end
    endtask

    task automatic send_stop();
        @(negedge clk) begin scl = 1'b0; sda = 1'b0; end
        @(negedge clk) scl = 1'b1;
        @(negedge clk) sda = 1'b1;
        @(negedge clk);
    endtask

    task automatic pulse_len(output int n);
        n = 0;
        while (wd_rst) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic set_sel(logic [1:0] s);
        @(negedge clk) sel = s;
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run hung, got 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        int n;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        expect_ports("R8 reset state", 0, 1);

        // R3 long period and R2 expiry edge
        ticks(PL - 1);
        expect_ports("R2 long no early expiry", 0, 1);
        ticks(1);
        expect_ports("R3 long period expiry", 1, 1);
        pulse_len(n);
        check_val("R5 pulse length", n, PW);
        ticks(PL - 1);
        expect_ports("R5 reload after pulse", 0, 1);
        ticks(1);
        expect_ports("R5 restart expiry", 1, 1);
        pulse_len(n);

        // R1 START refresh, R8 standby
        ticks(6);
        send_start(1'b0);
        expect_ports("R8 START clears standby", 0, 0);
        ticks(PL - 1);
        expect_ports("R1 START reloads counter", 0, 0);
        send_stop();
        expect_ports("R8 STOP sets standby", 0, 1);
        ticks(1);
        expect_ports("R1 expiry after full period", 1, 1);
        pulse_len(n);

        // R9 SDA toggles with SCL low
        ticks(6);
        @(negedge clk) begin scl = 1'b0; sda = 1'b1; end
        @(negedge clk) sda = 1'b0;
        @(negedge clk) sda = 1'b1;
        @(negedge clk) sda = 1'b0;
        @(negedge clk) scl = 1'b1;
        @(negedge clk) sda = 1'b1;
        @(negedge clk);
        expect_ports("R9 SCL-low toggles no condition", 0, 1);
        ticks(5);
        expect_ports("R9 counter not reloaded", 0, 1);
        ticks(1);
        expect_ports("R9 expiry unchanged", 1, 1);

        // R6 START during pulse
        send_start(1'b0);
        expect_ports("R6 START in pulse ignored", 1, 1);
        pulse_len(n);
        check_val("R6 pulse remainder", n, PW - 3);
        send_stop();

        // R6 START while supervisor reset
        ticks(6);
        @(negedge clk) sup = 1'b1;
        send_start(1'b0);
        @(negedge clk) sup = 1'b0;
        expect_ports("R6 START under supervisor reset ignored", 0, 1);
        send_stop();
        ticks(5);
        expect_ports("R6 no reload before expiry", 0, 1);
        ticks(1);
        expect_ports("R6 expiry on original count", 1, 1);
        pulse_len(n);

        // R3 R7 short and mid periods
        set_sel(2'b10);
        ticks(PS - 1);
        expect_ports("R3 short no early expiry", 0, -1);
        ticks(1);
        expect_ports("R3 short period expiry", 1, -1);
        pulse_len(n);
        set_sel(2'b01);
        ticks(PM - 1);
        expect_ports("R3 mid no early expiry", 0, -1);
        ticks(1);
        expect_ports("R3 mid period expiry", 1, -1);
        pulse_len(n);
        ticks(5);
        set_sel(2'b10);
        ticks(PS - 1);
        expect_ports("R7 change reloads new period", 0, -1);
        ticks(1);
        expect_ports("R7 expiry at new period", 1, -1);

        // R7 change during pulse ends it
        set_sel(2'b00);
        expect_ports("R7 change ends pulse", 0, -1);

        // R4 off
        set_sel(2'b11);
        ticks(3 * PL);
        expect_ports("R4 off never expires", 0, -1);
        set_sel(2'b00);
        ticks(PL - 1);
        expect_ports("R4 leaving off reloads", 0, -1);
        ticks(1);
        expect_ports("R4 long expiry after off", 1, -1);
        pulse_len(n);

        // R10 START and tick together
        ticks(5);
        send_start(1'b1);
        ticks(PL - 1);
        expect_ports("R10 START beats tick", 0, 0);
        ticks(1);
        expect_ports("R10 expiry after full period", 1, -1);
        send_stop();

        repeat (10) @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule